// File: doc/BRIEF.md
# ADC Multiplexer Frame Sequencer

This block shares one sampling converter among several analog input channels. Time is divided into frames. Each frame is a short list of channel slots. For every slot the block raises a conversion-start pulse and presents the channel number for that slot. It then counts the conversion time in ticks of a 32768 Hz timebase. At the end of the conversion it writes the result to a fixed memory word chosen by the slot index. The converter and its decimation filter sit outside this block. Their output arrives on `conv_data` and is valid on the last tick of each conversion.

Software controls the sequencer through a few configuration inputs, sampled only at the start of a frame:
- the number of slots per frame, from 2 to 4;
- a length select that chooses a 2-tick, 21-bit conversion or a 3-tick, 22-bit conversion;
- a two-bit control for the polarity of the reference chopper.

A rising edge on `alt_req` books one alternate frame. That frame uses a second slot-to-channel table and a second bank of memory words. The block also pulses a start signal once per frame for the downstream computation engine.

The block runs on the system clock. The timebase reaches it as the single-cycle enable `tick`. Every output is registered, so it changes on the clock edge that samples a tick.

Top module: `adc_frame_seq`

## Requirements
- R1: A frame runs the number of slots latched from `slots_cfg` (2, 3 or 4), always in order from slot 0. At the start of slot s, `chan_sel` equals field s (bits 3s+2 to 3s) of `norm_map` in a normal frame, or of `alt_map` in an alternate frame.
- R2: A conversion lasts 2 ticks when the latched `len_sel` is 0 and 3 ticks when it is 1. `conv_start` pulses for one clock on the first tick of each slot.
- R3: `wr_en` pulses for one clock on the last tick of each conversion. `wr_addr` is the slot index in a normal frame and the slot index plus 4 in an alternate frame.
- R4: `wr_data` is the conversion result shifted left by 9 bits, with zeros below. The result is the low 21 bits of `conv_data` (bit 21 forced to zero) when the latched `len_sel` is 0, and all 22 bits when it is 1.
- R5: Changes to `slots_cfg`, `len_sel` and `chop_mode` in the middle of a frame take effect only at the next frame start.
- R6: A rising edge on `alt_req` is captured even if the bit is high for a single clock. The next frame is then one alternate frame, followed by normal frames. `alt_active` is high for exactly that frame.
- R7: An alternate request captured during an alternate frame, or on the clock of a frame start, is held and served at the following frame boundary.
- R8: `chop_pol` is set at each frame start from `chop_mode`: 00 gives 0 (regular), 01 gives 1 (inverted), and 10 or 11 gives the inverse of its previous value (toggle). It never changes inside a frame.
- R9: `engine_start` pulses for one clock on the first tick of every frame and at no other time.
- R10: While `rst_n` is low, `wr_en`, `conv_start` and `engine_start` are 0 and `chop_pol` is 0. The first tick after release starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock enable per 32768 Hz timebase period |
| slots_cfg | input | 3 | Slots per frame (2 to 4) |
| len_sel | input | 1 | Conversion length: 0 = 2 ticks/21 bits, 1 = 3 ticks/22 bits |
| alt_req | input | 1 | Alternate-frame request, rising-edge sensitive |
| chop_mode | input | 2 | Chopper control: 00 regular, 01 inverted, 1x toggle |
| norm_map | input | 12 | Normal slot-to-channel table, 3 bits per slot |
| alt_map | input | 12 | Alternate slot-to-channel table, 3 bits per slot |
| conv_data | input | 22 | Converter result, valid on the last tick of a conversion |
| conv_start | output | 1 | Pulse at the start of each slot's conversion |
| chan_sel | output | 3 | Channel selected for the current slot |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 3 | Result memory word |
| wr_data | output | 31 | Shifted result |
| engine_start | output | 1 | Per-frame start pulse for the computation engine |
| alt_active | output | 1 | High for the whole of an alternate frame |
| chop_pol | output | 1 | Reference chopper polarity |

## Verification
The assertions assume three things about the inputs:
- `slots_cfg` holds a legal count of 2 to 4 whenever a frame starts;
- `tick` is never high on two clocks in a row;
- `alt_req` is low when reset is released, so that release is not read as a request.

The stimulus keeps within these limits. It raises `tick` for one clock out of every two or more, and it sweeps only the legal slot counts. It changes the configuration at arbitrary points inside frames, and it raises `alt_req` only between ticks, starting from a low level after reset.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      CHOP_REGULAR = 2'b00,
      CHOP_INVERT  = 2'b01,
      CHOP_FLIP_A  = 2'b10,
      CHOP_FLIP_B  = 2'b11
   } chop_mode_e;

   function automatic logic chop_next(input logic [1:0] mode, input logic cur);
      case (mode)
         CHOP_REGULAR: chop_next = 1'b0;
         CHOP_INVERT:  chop_next = 1'b1;
         default:      chop_next = ~cur;
      endcase
   endfunction
endpackage

// File: rtl/adcseq_edge_latch.sv
module adcseq_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic consume,
   output logic pend
);
   logic req_q;
   logic rise;

   assign rise = req && !req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         pend  <= 1'b0;
      end else begin
         req_q <= req;
         pend  <= (pend && !consume) || rise;
      end
   end

   // A one-clock-wide request must still be booked.
   assert_rise_booked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !req_q) |=> pend);
   // A booked request not consumed stays booked.
   assert_pend_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !consume) |=> pend);
endmodule

// File: rtl/adcseq_slot_timer.sv
module adcseq_slot_timer #(
   parameter int MAX_SLOTS   = 4,
   parameter int SHORT_TICKS = 2,
   parameter int LONG_TICKS  = 3,
   localparam int SW   = $clog2(MAX_SLOTS),
   localparam int CFGW = $clog2(MAX_SLOTS + 1),
   localparam int CW   = $clog2(LONG_TICKS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [CFGW-1:0] slots_cfg,
   input  logic            len_sel,
   output logic            frame_start,
   output logic            slot_start,
   output logic            conv_end,
   output logic [SW-1:0]   slot,
   output logic            long_q
);
   if (MAX_SLOTS < 2) begin : g_bad_slots
      $error("MAX_SLOTS must be at least 2");
   end
   if (SHORT_TICKS < 2 || LONG_TICKS <= SHORT_TICKS) begin : g_bad_len
      $error("conversion lengths must satisfy 2 <= SHORT_TICKS < LONG_TICKS");
   end

   logic [CW-1:0]   cnt_q;
   logic [CFGW-1:0] nsl_q;
   logic [CW-1:0]   lim;
   logic            last_slot;

   assign lim         = long_q ? CW'(LONG_TICKS - 1) : CW'(SHORT_TICKS - 1);
   assign frame_start = tick && (slot == '0) && (cnt_q == '0);
   assign slot_start  = tick && (cnt_q == '0);
   assign conv_end    = tick && (cnt_q == lim);
   assign last_slot   = (CFGW'(slot) == nsl_q - CFGW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot   <= '0;
         cnt_q  <= '0;
         nsl_q  <= CFGW'(MAX_SLOTS);
         long_q <= 1'b0;
      end else if (tick) begin
         if (frame_start) begin
            nsl_q  <= slots_cfg;
            long_q <= len_sel;
         end
         if (conv_end) begin
            cnt_q <= '0;
            slot  <= last_slot ? '0 : slot + SW'(1);
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   // Input assumption: a legal slot count is present whenever a frame opens.
   assert_cfg_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (slots_cfg >= CFGW'(2) && slots_cfg <= CFGW'(MAX_SLOTS)));
   // The slot index never runs past the latched count.
   assert_slot_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !frame_start) |-> (CFGW'(slot) < nsl_q));
   // Input assumption: the timebase enable is a single-clock pulse.
   assert_tick_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/adcseq_result_fmt.sv
module adcseq_result_fmt #(
   parameter int DW    = 22,
   parameter int SHIFT = 9,
   localparam int MW   = DW + SHIFT
) (
   input  logic          long_res,
   input  logic [DW-1:0] data,
   output logic [MW-1:0] word
);
   if (DW < 2) begin : g_bad_dw
      $error("DW must be at least 2");
   end

   logic [DW-1:0] kept;
   assign kept = long_res ? data : {1'b0, data[DW-2:0]};

   if (SHIFT == 0) begin : g_noshift
      assign word = kept;
   end else begin : g_shift
      assign word = {kept, {SHIFT{1'b0}}};
   end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq #(
   parameter int MAX_SLOTS   = 4,
   parameter int CHW         = 3,
   parameter int DW          = 22,
   parameter int SHIFT       = 9,
   parameter int SHORT_TICKS = 2,
   parameter int LONG_TICKS  = 3,
   localparam int SW   = $clog2(MAX_SLOTS),
   localparam int CFGW = $clog2(MAX_SLOTS + 1),
   localparam int AW   = $clog2(2 * MAX_SLOTS),
   localparam int MW   = DW + SHIFT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic [CFGW-1:0]          slots_cfg,
   input  logic                     len_sel,
   input  logic                     alt_req,
   input  logic [1:0]               chop_mode,
   input  logic [MAX_SLOTS*CHW-1:0] norm_map,
   input  logic [MAX_SLOTS*CHW-1:0] alt_map,
   input  logic [DW-1:0]            conv_data,
   output logic                     conv_start,
   output logic [CHW-1:0]           chan_sel,
   output logic                     wr_en,
   output logic [AW-1:0]            wr_addr,
   output logic [MW-1:0]            wr_data,
   output logic                     engine_start,
   output logic                     alt_active,
   output logic                     chop_pol
);
   import adc_seq_pkg::*;

   if (CHW < 1) begin : g_bad_chw
      $error("CHW must be at least 1");
   end

   logic          frame_start, slot_start, conv_end, long_q, alt_pend, use_alt;
   logic [SW-1:0] slot;
   logic [MW-1:0] fmt_word;
   logic [CHW-1:0] nmap [MAX_SLOTS];
   logic [CHW-1:0] amap [MAX_SLOTS];

   for (genvar i = 0; i < MAX_SLOTS; i++) begin : g_unpack
      assign nmap[i] = norm_map[i*CHW +: CHW];
      assign amap[i] = alt_map[i*CHW +: CHW];
   end

   adcseq_slot_timer #(
      .MAX_SLOTS(MAX_SLOTS), .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .slots_cfg(slots_cfg), .len_sel(len_sel),
      .frame_start(frame_start), .slot_start(slot_start), .conv_end(conv_end),
      .slot(slot), .long_q(long_q)
   );

   adcseq_edge_latch u_alt (
      .clk(clk), .rst_n(rst_n), .req(alt_req), .consume(frame_start), .pend(alt_pend)
   );

   adcseq_result_fmt #(.DW(DW), .SHIFT(SHIFT)) u_fmt (
      .long_res(long_q), .data(conv_data), .word(fmt_word)
   );

   assign use_alt = frame_start ? alt_pend : alt_active;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conv_start   <= 1'b0;
         chan_sel     <= '0;
         wr_en        <= 1'b0;
         wr_addr      <= '0;
         wr_data      <= '0;
         engine_start <= 1'b0;
         alt_active   <= 1'b0;
         chop_pol     <= 1'b0;
      end else begin
         conv_start   <= 1'b0;
         wr_en        <= 1'b0;
         engine_start <= 1'b0;
         if (slot_start) begin
            conv_start <= 1'b1;
            chan_sel   <= use_alt ? amap[slot] : nmap[slot];
         end
         if (frame_start) begin
            engine_start <= 1'b1;
            alt_active   <= alt_pend;
            chop_pol     <= chop_next(chop_mode, chop_pol);
         end
         if (conv_end) begin
            wr_en   <= 1'b1;
            wr_addr <= AW'(slot) + (alt_active ? AW'(MAX_SLOTS) : AW'(0));
            wr_data <= fmt_word;
         end
      end
   end

   // Polarity moves only together with a frame start.
   assert_pol_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(chop_pol) |-> engine_start);
   // The alternate flag moves only at a frame boundary.
   assert_alt_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(alt_active) |-> engine_start);
   // Every frame start also opens the first slot.
   assert_eng_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      engine_start |-> conv_start);
   // A write and a slot start never fall on the same tick.
   assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && conv_start));
   // Input assumption: alt_req is low as reset is released.
   assert_alt_quiet_R10: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || !alt_req));
endmodule

// File: tb/sim_adc_frame_seq.sv
module sim_adc_frame_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [2:0]  slots_cfg = 3'd4;
   logic        len_sel = 1'b0;
   logic        alt_req = 1'b0;
   logic [1:0]  chop_mode = 2'b01;
   logic [11:0] norm_map;
   logic [11:0] alt_map;
   logic [21:0] conv_data = '0;
   logic        conv_start, wr_en, engine_start, alt_active, chop_pol;
   logic [2:0]  chan_sel, wr_addr;
   logic [30:0] wr_data;

   int checks = 0;
   int errors = 0;
   int nch [4] = '{5, 1, 6, 2};
   int ach [4] = '{3, 7, 0, 4};

   // model state
   int o = 0, n_m = 4, l_m = 2, tk = 0;
   bit alt_m = 0, pend_m = 0, pol_m = 0;

   always #4 clk = ~clk;

   assign norm_map = {3'(nch[3]), 3'(nch[2]), 3'(nch[1]), 3'(nch[0])};
   assign alt_map  = {3'(ach[3]), 3'(ach[2]), 3'(ach[1]), 3'(ach[0])};

   adc_frame_seq u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .slots_cfg(slots_cfg), .len_sel(len_sel),
      .alt_req(alt_req), .chop_mode(chop_mode), .norm_map(norm_map), .alt_map(alt_map),
      .conv_data(conv_data), .conv_start(conv_start), .chan_sel(chan_sel), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .engine_start(engine_start),
      .alt_active(alt_active), .chop_pol(chop_pol)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s tick %0d: actual %0h expected %0h", tag, tk, act, exp);
      end
   endtask

   task automatic step();
      int s, c;
      logic [21:0] dv;
      logic [30:0] ed;
      if (o == 0) begin
         n_m    = int'(slots_cfg);
         l_m    = len_sel ? 3 : 2;
         alt_m  = pend_m;
         pend_m = 0;
         pol_m  = (chop_mode == 2'b00) ? 1'b0 : (chop_mode == 2'b01) ? 1'b1 : ~pol_m;
      end
      s  = o / l_m;
      c  = o % l_m;
      dv = 22'((tk * 32'h0001F3A7) ^ (tk << 15));
      ed = {(l_m == 3) ? dv : {1'b0, dv[20:0]}, 9'b0};
      @(negedge clk);
      tick = 1'b1;
      conv_data = dv;
      @(negedge clk);
      tick = 1'b0;
      chk("R2 conv_start", 32'(conv_start), 32'(c == 0));
      chk("R9 engine_start", 32'(engine_start), 32'(o == 0));
      chk("R3 wr_en", 32'(wr_en), 32'(c == l_m - 1));
      chk("R6 R7 alt_active", 32'(alt_active), 32'(alt_m));
      chk("R8 chop_pol", 32'(chop_pol), 32'(pol_m));
      if (c == 0) chk("R1 chan_sel", 32'(chan_sel), 32'(alt_m ? ach[s] : nch[s]));
      if (c == l_m - 1) begin
         chk("R3 wr_addr", 32'(wr_addr), 32'(s + (alt_m ? 4 : 0)));
         chk("R4 wr_data", 32'(wr_data), 32'(ed));
      end
      o++;
      if (o == n_m * l_m) o = 0;
      tk++;
   endtask

   task automatic pulse_alt();
      @(negedge clk);
      alt_req = 1'b1;
      @(negedge clk);
      alt_req = 1'b0;
      pend_m = 1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R10: outputs quiet in reset even with tick pulses and inverted mode
      repeat (3) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         chk("R10 wr_en in reset", 32'(wr_en), 0);
         chk("R10 engine_start in reset", 32'(engine_start), 0);
         chk("R10 conv_start in reset", 32'(conv_start), 0);
         chk("R10 chop_pol in reset", 32'(chop_pol), 0);
      end
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // first tick after release opens a frame (R10 via engine_start check)
      step();
      chk("R10 first frame", 32'(engine_start), 1);
      // R1 R2 R5 R8 sweep: changes land at arbitrary points inside frames
      for (int n = 2; n <= 4; n++) begin
         for (int l = 0; l < 2; l++) begin
            for (int m = 0; m < 4; m++) begin
               slots_cfg = 3'(n);
               len_sel   = 1'(l);
               chop_mode = 2'(m);
               repeat (13) step();
            end
         end
      end
      // R6: single one-clock request mid-frame, then normal frames after
      slots_cfg = 3'd3; len_sel = 1'b0; chop_mode = 2'b10;
      repeat (2) step();
      pulse_alt();
      repeat (20) step();
      // R7: request during alternate frame is held for the following one
      pulse_alt();
      while (!(o == 2 && alt_m)) step();
      pulse_alt();
      repeat (30) step();
      // R7: request right after a frame-start tick
      len_sel = 1'b1; slots_cfg = 3'd4;
      while (o != 1) step();
      pulse_alt();
      repeat (40) step();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule